// File: doc/BRIEF.md
# Power-channel I2C control register

This block is a two-wire serial slave that owns the single 8-bit system register of one supply channel. A host writes the register by sending an address byte with the write flag followed by one data byte, and reads it back by sending the address byte with the read flag and clocking out as many bytes as it acknowledges. Only the upper six bits are stored. The lower two bits are live copies of an overload flag and an over-temperature flag that are driven from outside.

The stored bits are decoded into the channel controls: output enable, a two-bit voltage-level code, continuous tone enable, transmit-path select and current-limit mode. A supply-good input clears the register and keeps the slave silent on the bus while it is low. The serial lines are sampled by a two-flop synchronizer with edge detection on a system clock at least eight times the serial clock rate. Clock stretching, general call and 10-bit addressing are not supported.

The slave is built around an enumerated state machine with states IDLE, ADDR (shift in the address byte), ADDR_ACK, WR_DATA (shift in the data byte), WR_ACK, RD_DATA (shift out a byte), RD_ACK (sample the host's acknowledge) and WAIT (ignore the bus until START or STOP). Transitions: a START moves any state to ADDR. A STOP moves any state to IDLE. A low supply-good moves any state to IDLE. ADDR goes to ADDR_ACK on the falling edge after eight bits when the address matches, and to WAIT when it does not. ADDR_ACK goes to RD_DATA or WR_DATA on the next falling edge, depending on the direction flag. WR_DATA commits the byte and goes to WR_ACK after eight bits. WR_ACK goes to WAIT. RD_DATA goes to RD_ACK after eight bits. RD_ACK goes back to RD_DATA when the host acknowledged, and to WAIT when it did not.

Top module: `psu_i2c_ctrl`

## Requirements
- R1: The slave answers only the 7-bit address 0001000 with its low two bits replaced by `strap_addr` (0x08 to 0x0B). Any other address gets no acknowledge, and the register is left unchanged.
- R2: A write consists of the address byte with bit 0 = 0, then one data byte, both sent MSB first. The slave pulls SDA low in the ninth clock of each of the two bytes, and the data byte is stored when its eighth bit completes.
- R3: Only data bits 7:2 are stored. Writes to bits 1:0 are discarded. On read, bit 1 is `flag_overtemp` and bit 0 is `flag_overload`, as they are when the byte is loaded.
- R4: A read (address bit 0 = 1) returns {stored[7:2], flag_overtemp, flag_overload} MSB first. If the host acknowledges, the same register byte follows again. If the host does not acknowledge, the slave stops driving SDA until the next START.
- R5: While `supply_ok` is low, the register reads as all zeros, all channel outputs are in their reset values, and the slave never pulls SDA.
- R6: After reset the register is zero: out_en=0, out_vcode=00, out_tone=0, out_tx_sel=0, out_pulsed_limit=1, sda_pull=0.
- R7: A write transaction that ends with STOP right after the address acknowledge leaves the register unchanged.
- R8: A START or STOP in the middle of a data byte aborts that byte without storing it. After a repeated START the slave decodes a fresh address byte.
- R9: The register bits are laid out as bit 7 PCL, bit 6 TTX, bit 5 TEN, bit 4 LLC, bit 3 VSEL and bit 2 EN. out_en = bit 2. out_vcode = {bit 3, bit 4}, where 00 is 13.25 V, 01 is 14.25 V, 10 is 18 V and 11 is 19.5 V. out_tone = bit 5, out_tx_sel = bit 6. When bit 2 is 0, out_vcode, out_tone and out_tx_sel are all 0.
- R10: out_pulsed_limit is the inverse of register bit 7: 0 selects pulsed limiting (out_pulsed_limit=1), and 1 selects a static clamp (out_pulsed_limit=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good; low clears the register and silences the slave |
| strap_addr | input | 2 | Selects the low two bits of the slave address |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | 1 drives SDA low (open-drain enable) |
| flag_overload | input | 1 | Live overload status, read as bit 0 |
| flag_overtemp | input | 1 | Live over-temperature status, read as bit 1 |
| out_en | output | 1 | Channel power enable |
| out_vcode | output | 2 | Voltage-level code {VSEL, LLC}, zero when disabled |
| out_tone | output | 1 | Continuous tone enable, gated by enable |
| out_tx_sel | output | 1 | Transmit output path select, gated by enable |
| out_pulsed_limit | output | 1 | 1 selects pulsed current limiting |

## Verification
The bench sweeps all four strap settings against all four candidate addresses, plus two addresses that differ only in their upper bits. A faulty address compare would either acknowledge a foreign address or stay silent on its own, and in both cases the register read-back would diverge. All 64 values of the stored field are written with junk in the low bits and varied status flags, then read back. This catches a register that keeps the low bits, swaps LLC and VSEL in the voltage code, or fails to gate the outputs on enable. The remaining tests cover aborted transfers, a two-byte read followed by a NACK, and a supply drop. A design that committed a partial byte, kept driving SDA after a NACK, or acknowledged while unpowered would be caught.

// File: rtl/psu_i2c_pkg.sv
package psu_i2c_pkg;

    localparam int BYTE_W  = 8;

    // Register bit positions (MSB to LSB)
    localparam int B_PCL   = 7;
    localparam int B_TTX   = 6;
    localparam int B_TEN   = 5;
    localparam int B_LLC   = 4;
    localparam int B_VSEL  = 3;
    localparam int B_EN    = 2;
    localparam int B_OTF   = 1;
    localparam int B_OLF   = 0;

    // Lowest writable bit and width of the stored field
    localparam int CTL_LSB = 2;
    localparam int CTL_W   = BYTE_W - CTL_LSB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int NLINES = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_in,
    output logic [NLINES-1:0] lvl,
    output logic [NLINES-1:0] rise,
    output logic [NLINES-1:0] fall
);

    generate
        for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;

            // The bus idles high, so reset to 1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], lines_in[gi]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign lvl[gi]  = chain[STAGES-1];
            assign rise[gi] = chain[STAGES-1] & ~prev;
            assign fall[gi] = ~chain[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import psu_i2c_pkg::*;
#(
    parameter logic [6:0] SLV_BASE = 7'h08,
    parameter int         STRAP_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic [STRAP_W-1:0] strap,
    input  logic               scl_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               sda_rise,
    input  logic               sda_fall,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic [BYTE_W-1:0]  wr_byte,
    output logic               wr_commit,
    output logic               sda_pull
);

    localparam int              CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [6:0]      MY_ADDR_HI = SLV_BASE;

    slv_state_t              state, state_n;
    logic [BYTE_W-1:0]       rx_sr;
    logic [BYTE_W-1:0]       tx_sr;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    host_ack;
    logic                    bus_start, bus_stop;
    logic                    addr_hit;
    logic [6:0]              my_addr;

    // START/STOP: SDA edge while SCL stayed high over two samples
    assign bus_start = scl_lvl & ~scl_rise & sda_fall;
    assign bus_stop  = scl_lvl & ~scl_rise & sda_rise;

    assign my_addr  = {MY_ADDR_HI[6:STRAP_W], strap};
    assign addr_hit = (rx_sr[BYTE_W-1:1] == my_addr);

    // Next-state logic
    always_comb begin
        state_n = state;
        if (!pwr_ok) begin
            state_n = ST_IDLE;
        end else if (bus_start) begin
            state_n = ST_ADDR;
        end else if (bus_stop) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:
                    if (scl_fall && bit_cnt == CNT_FULL)
                        state_n = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:
                    if (scl_fall)
                        state_n = rx_sr[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:
                    if (scl_fall && bit_cnt == CNT_FULL)
                        state_n = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall)
                        state_n = ST_WAIT;
                ST_RD_DATA:
                    if (scl_fall && bit_cnt == CNT_LAST)
                        state_n = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall)
                        state_n = host_ack ? ST_RD_DATA : ST_WAIT;
                ST_WAIT:     state_n = ST_WAIT;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Shift registers, bit counter and host acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr    <= '0;
            tx_sr    <= '0;
            bit_cnt  <= '0;
            host_ack <= 1'b0;
        end else if (!pwr_ok || bus_start || bus_stop) begin
            bit_cnt  <= '0;
            host_ack <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise) begin
                        rx_sr   <= {rx_sr[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == CNT_FULL) begin
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        tx_sr   <= rd_byte;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) host_ack <= ~sda_lvl;
                    if (scl_fall) begin
                        tx_sr   <= rd_byte;
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_pull  = 1'b0;
        wr_commit = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_DATA:             sda_pull = ~tx_sr[BYTE_W-1];
            ST_WR_DATA:             wr_commit = pwr_ok & ~bus_start & ~bus_stop
                                                & scl_fall & (bit_cnt == CNT_FULL);
            default: ;
        endcase
    end

    assign wr_byte = rx_sr;

endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
    import psu_i2c_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output logic             en,
    output logic [1:0]       vcode,
    output logic             tone,
    output logic             tx_sel,
    output logic             pulsed_limit
);

    always_comb begin
        en           = ctl[B_EN - CTL_LSB];
        vcode        = en ? {ctl[B_VSEL - CTL_LSB], ctl[B_LLC - CTL_LSB]} : 2'b00;
        tone         = en & ctl[B_TEN - CTL_LSB];
        tx_sel       = en & ctl[B_TTX - CTL_LSB];
        pulsed_limit = ~ctl[B_PCL - CTL_LSB];
    end

endmodule

// File: rtl/psu_i2c_ctrl.sv
module psu_i2c_ctrl
    import psu_i2c_pkg::*;
#(
    parameter logic [6:0] SLV_BASE    = 7'h08,
    parameter int         STRAP_W     = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_ok,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               flag_overload,
    input  logic               flag_overtemp,
    output logic               out_en,
    output logic [1:0]         out_vcode,
    output logic               out_tone,
    output logic               out_tx_sel,
    output logic               out_pulsed_limit
);

    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [1:0]        l_lvl, l_rise, l_fall;
    logic [CTL_W-1:0]  ctl_q;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] wr_byte;
    logic              wr_commit;

    i2c_line_sync #(
        .NLINES (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in ({scl_in, sda_in}),
        .lvl      (l_lvl),
        .rise     (l_rise),
        .fall     (l_fall)
    );

    assign rd_byte = {ctl_q, flag_overtemp, flag_overload};

    i2c_slave_fsm #(
        .SLV_BASE (SLV_BASE),
        .STRAP_W  (STRAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (supply_ok),
        .strap     (strap_addr),
        .scl_lvl   (l_lvl[IDX_SCL]),
        .scl_rise  (l_rise[IDX_SCL]),
        .scl_fall  (l_fall[IDX_SCL]),
        .sda_lvl   (l_lvl[IDX_SDA]),
        .sda_rise  (l_rise[IDX_SDA]),
        .sda_fall  (l_fall[IDX_SDA]),
        .rd_byte   (rd_byte),
        .wr_byte   (wr_byte),
        .wr_commit (wr_commit),
        .sda_pull  (sda_pull)
    );

    // Stored field: bits 7:2 only, cleared while supply is bad
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ctl_q <= '0;
        else if (!supply_ok) ctl_q <= '0;
        else if (wr_commit)  ctl_q <= wr_byte[BYTE_W-1:CTL_LSB];
    end

    ctrl_decode u_dec (
        .ctl          (ctl_q),
        .en           (out_en),
        .vcode        (out_vcode),
        .tone         (out_tone),
        .tx_sel       (out_tx_sel),
        .pulsed_limit (out_pulsed_limit)
    );

endmodule

// File: rtl/psu_i2c_ctrl_chk.sv
module psu_i2c_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       scl_in,
    input logic       sda_pull,
    input logic       wr_commit,
    input logic       out_en,
    input logic [1:0] out_vcode,
    input logic       out_tone,
    input logic       out_tx_sel,
    input logic       out_pulsed_limit
);

    // R5: an unpowered slave never drives the bus
    assert_silent_unpowered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !sda_pull);

    // R5: an unpowered slave presents reset-valued controls
    assert_outputs_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!out_en && out_pulsed_limit));

    // R9: a disabled channel drives no level, tone or TX path
    assert_gated_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (out_vcode == 2'b00 && !out_tone && !out_tx_sel));

    // R2: controls move only after a data byte commit
    assert_stable_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_commit) && $past(supply_ok)) |->
            ($stable(out_en) && $stable(out_vcode) && $stable(out_tone)
             && $stable(out_tx_sel) && $stable(out_pulsed_limit)));

    // R4: the slave changes SDA only while SCL is low
    assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && supply_ok && $past(supply_ok)) |-> !scl_in);

endmodule

bind psu_i2c_ctrl psu_i2c_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .supply_ok        (supply_ok),
    .scl_in           (scl_in),
    .sda_pull         (sda_pull),
    .wr_commit        (wr_commit),
    .out_en           (out_en),
    .out_vcode        (out_vcode),
    .out_tone         (out_tone),
    .out_tx_sel       (out_tx_sel),
    .out_pulsed_limit (out_pulsed_limit)
);

// File: tb/tb_psu_i2c_ctrl.sv
module tb_psu_i2c_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;      // quarter SCL period in clk cycles
    localparam int WDOG       = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b1;
    logic [1:0] strap = 2'd0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       ovl = 1'b0;
    logic       otmp = 1'b0;
    logic       sda_pull;
    logic       out_en, out_tone, out_tx_sel, out_pulsed_limit;
    logic [1:0] out_vcode;
    wire        sda_line = msda & ~sda_pull;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:2] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psu_i2c_ctrl dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .supply_ok        (supply_ok),
        .strap_addr       (strap),
        .scl_in           (scl),
        .sda_in           (sda_line),
        .sda_pull         (sda_pull),
        .flag_overload    (ovl),
        .flag_overtemp    (otmp),
        .out_en           (out_en),
        .out_vcode        (out_vcode),
        .out_tone         (out_tone),
        .out_tx_sel       (out_tx_sel),
        .out_pulsed_limit (out_pulsed_limit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        msda = 1'b1; wq(Q);
        scl  = 1'b1; wq(Q);
        msda = 1'b0; wq(Q);
        scl  = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        msda = 1'b0; wq(Q);
        scl  = 1'b1; wq(Q);
        msda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        msda = b;    wq(Q);
        scl  = 1'b1; wq(2*Q);
        scl  = 1'b0; wq(Q);
    endtask

    task automatic read_bit(output logic b);
        msda = 1'b1; wq(Q);
        scl  = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl  = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        read_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] d,
                          output logic ack_a, output logic ack_d);
        i2c_start();
        send_byte({a, 1'b0}, ack_a);
        send_byte(d, ack_d);
        i2c_stop();
        wq(4);
    endtask

    task automatic rd_txn(input logic [6:0] a, output logic ack_a,
                          output logic [7:0] d);
        logic [7:0] tmp;
        i2c_start();
        send_byte({a, 1'b1}, ack_a);
        read_byte(tmp, 1'b0);
        d = tmp;
        i2c_stop();
        wq(4);
    endtask

    task automatic check_outputs(input string tag);
        logic       en;
        logic [1:0] vc;
        en = model[2];
        vc = en ? {model[3], model[4]} : 2'b00;
        chk(out_en == en, {tag, " R9 en"}, out_en, en);
        chk(out_vcode == vc, {tag, " R9 vcode"}, out_vcode, vc);
        chk(out_tone == (en & model[5]), {tag, " R9 tone"}, out_tone, en & model[5]);
        chk(out_tx_sel == (en & model[6]), {tag, " R9 tx_sel"}, out_tx_sel, en & model[6]);
        chk(out_pulsed_limit == ~model[7], {tag, " R10 limit"}, out_pulsed_limit, ~model[7]);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       aa, ad, b;
        logic [7:0] rd, rd2;

        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R6: reset values
        chk(out_en == 1'b0, "R6 en", out_en, 0);
        chk(out_vcode == 2'b00, "R6 vcode", out_vcode, 0);
        chk(out_tone == 1'b0 && out_tx_sel == 1'b0, "R6 tone/tx", {out_tone, out_tx_sel}, 0);
        chk(out_pulsed_limit == 1'b1, "R6 limit", out_pulsed_limit, 1);
        chk(sda_pull == 1'b0, "R6 sda", sda_pull, 0);

        // R1: strap x address sweep
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 0; a < 4; a++) begin
                logic [7:0] d;
                d = 8'((a * 4 + s) << 2) | 8'h03;
                wr_txn(7'(8 + a), d, aa, ad);
                chk(aa == (a == s), "R1 addr ack", aa, a == s);
                chk(ad == (a == s), "R2 data ack", ad, a == s);
                if (a == s) model = d[7:2];
                rd_txn(7'(8 + s), aa, rd);
                chk(rd[7:2] == model, "R1 reg after addr", rd[7:2], model);
            end
        end
        strap = 2'd1;
        wr_txn(7'h49, 8'hFC, aa, ad);
        chk(!aa, "R1 upper-bit alias 0x49", aa, 0);
        wr_txn(7'h19, 8'hFC, aa, ad);
        chk(!aa, "R1 upper-bit alias 0x19", aa, 0);
        rd_txn(7'h09, aa, rd);
        chk(rd[7:2] == model, "R1 reg unchanged by alias", rd[7:2], model);

        // R2/R3/R4/R9/R10: all stored values
        strap = 2'd3;
        for (int v = 0; v < 64; v++) begin
            logic [7:0] d, exp;
            d    = {6'(v), 2'(v + 1)};
            ovl  = 1'(v) ^ 1'(v >> 3);
            otmp = 1'(v >> 2);
            wr_txn(7'h0B, d, aa, ad);
            chk(aa && ad, "R2 write acks", {aa, ad}, 3);
            model = d[7:2];
            check_outputs("sweep");
            rd_txn(7'h0B, aa, rd);
            exp = {model, otmp, ovl};
            chk(rd == exp, "R3 R4 readback", rd, exp);
        end

        // R4: host ACK gives a second byte, NACK releases the bus
        ovl = 1'b1; otmp = 1'b0;
        i2c_start();
        send_byte({7'h0B, 1'b1}, aa);
        read_byte(rd, 1'b1);
        read_byte(rd2, 1'b0);
        chk(rd == {model, 2'b01}, "R4 first byte", rd, {model, 2'b01});
        chk(rd2 == rd, "R4 repeated byte", rd2, rd);
        read_bit(b);
        chk(b == 1'b1, "R4 released after NACK", b, 1);
        i2c_stop();
        wq(4);

        // R7: address-only write
        model = 6'b000101;
        wr_txn(7'h0B, {model, 2'b00}, aa, ad);
        i2c_start();
        send_byte({7'h0B, 1'b0}, aa);
        i2c_stop();
        wq(4);
        chk(aa, "R7 addr ack", aa, 1);
        check_outputs("R7");

        // R8: repeated START inside a data byte
        i2c_start();
        send_byte({7'h0B, 1'b0}, aa);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_start();
        send_byte({7'h0B, 1'b1}, aa);
        read_byte(rd, 1'b0);
        i2c_stop();
        wq(4);
        chk(aa, "R8 readdress ack", aa, 1);
        chk(rd[7:2] == model, "R8 partial byte dropped", rd[7:2], model);
        check_outputs("R8 restart");

        // R8: STOP inside a data byte
        i2c_start();
        send_byte({7'h0B, 1'b0}, aa);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        i2c_stop();
        wq(4);
        check_outputs("R8 stop");

        // R5: supply drop
        model = 6'b111111;
        wr_txn(7'h0B, 8'hFF, aa, ad);
        supply_ok = 1'b0;
        wq(4);
        model = '0;
        check_outputs("R5 unpowered");
        wr_txn(7'h0B, 8'hFC, aa, ad);
        chk(!aa && !ad, "R5 no ack unpowered", {aa, ad}, 0);
        chk(out_en == 1'b0, "R5 write ignored", out_en, 0);
        supply_ok = 1'b1;
        wq(4);
        rd_txn(7'h0B, aa, rd);
        chk(rd[7:2] == 6'd0, "R5 cleared after drop", rd[7:2], 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule